// File: doc/BRIEF.md
# DRAM Activate Timing Guard

The guard sits next to a DRAM command scheduler and answers one question each cycle: may a row-activate to the rank and bank the scheduler is asking about go out now? It tracks three limits that every activate moves at once. The first is a short spacing limit applied to every bank of the rank. The second is a longer limit on the bank that was opened, covering the time the row must stay open and then be precharged. The third is a rolling cap on how many activates a rank may issue inside a time window. The state for each rank is kept apart from the state of every other rank.

The scheduler presents a request (valid, rank, bank) and reads `act_ok` back in the same cycle. If it commits the activate, it raises `issue` for that cycle, and the guard records the activate at the next rising clock edge. Time is measured by a free-running cycle counter. Every limit is a stamp on that counter with a hold flag, so the comparisons stay correct when the counter wraps. The spacing limit, the open-plus-precharge limit, the window length and the activate cap are all parameters. A window length of zero turns the rolling check off.

Each bank has a two-state machine. FREE means no limit is pending. HOLD means an earliest-activate stamp is pending. FREE moves to HOLD when an activate is committed to the bank's rank. HOLD moves back to FREE in the cycle the counter reaches the stamp. HOLD stays in HOLD, with the stamp moved out, when a new committed activate pushes the limit further out.

Top module: `act_guard_top`

## Requirements
- R1: After reset every in-range request is allowed: `act_ok` is 1 and `stall` is 0 for every rank and bank while `req_valid` is 1.
- R2: `act_ok` is 0 whenever `req_valid` is 0. `stall` is 1 exactly when `req_valid` is 1 and `act_ok` is 0.
- R3: A committed activate to rank r at cycle T blocks every other bank of rank r until cycle T+T_RRD. From that cycle the bank is allowed, unless another limit still applies.
- R4: A committed activate to rank r, bank b at cycle T blocks bank b itself until cycle T + max(T_RAS, T_RCD+T_CL) + T_RP.
- R5: An activate to one rank changes no limit of any other rank.
- R6: With T_XAW > 0, a rank that has committed ACT_LIMIT activates has a window limit. Its next activate is allowed only from the cycle where the oldest of its last ACT_LIMIT activates is at least T_XAW cycles in the past.
- R7: With T_XAW = 0, no window limit applies. Only the limits of R3 and R4 gate `act_ok`.
- R8: If `issue` is 1 while `act_ok` is 0, `proto_err` is 1 in that cycle and the strobe is ignored. No limit changes, so `act_ok` on the following cycles is the same as if no strobe had come.
- R9: A later activate never brings a bank's pending limit earlier. A bank held until cycle X by its own activate stays blocked until X even if a sibling's spacing limit would end sooner.
- R10: The limits stay correct across wrap-around of the internal cycle counter (width TS_W). This holds as long as every delay is below 2^TS_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | An activate request is presented |
| req_rank | input | RANK_W | Rank of the requested activate |
| req_bank | input | BANK_W | Bank of the requested activate |
| issue | input | 1 | Registered strobe: the presented activate is committed this cycle |
| act_ok | output | 1 | The presented activate may issue this cycle |
| stall | output | 1 | A request is presented and must wait |
| proto_err | output | 1 | `issue` came while `act_ok` was low; the strobe is dropped |

## Verification
`act_ok`, `stall` and `proto_err` are combinational functions of the request and the stored limits. They are due in the same cycle the request is presented. A committed activate changes the limits at the rising edge where `issue` is sampled, so its effect is first seen in the next cycle. The bench drives inputs on the falling edge, compares all three outputs 1 ns later against a model that uses absolute cycle numbers, and then advances the model at the rising edge. This matches the one-edge update latency. A second instance with the window disabled receives the same stimulus, and a narrow counter makes wrap-around happen many times during the run.

// File: rtl/act_guard_pkg.sv
package act_guard_pkg;

    // Per-bank limit state: no pending limit, or waiting for a stamp.
    typedef enum logic {
        BK_FREE = 1'b0,
        BK_HOLD = 1'b1
    } bank_state_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/act_bank_timer.sv
module act_bank_timer
    import act_guard_pkg::*;
#(
    parameter int TS_W    = 16,
    parameter int T_SHORT = 5,
    parameter int T_LONG  = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TS_W-1:0] now,
    input  logic            rank_go,
    input  logic            bank_go,
    output logic            ready
);

    bank_state_e     state, state_n;
    logic [TS_W-1:0] stamp, stamp_n;
    logic            expired;
    logic [TS_W-1:0] remain;

    assign expired = (now == stamp);
    assign remain  = stamp - now;
    assign ready   = (state == BK_FREE) || expired;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= BK_FREE;
            stamp <= '0;
        end else begin
            state <= state_n;
            stamp <= stamp_n;
        end
    end

    always_comb begin
        state_n = state;
        stamp_n = stamp;
        unique case (state)
            BK_FREE: state_n = BK_FREE;
            BK_HOLD: if (expired) state_n = BK_FREE;
        endcase
        if (rank_go) begin
            if (bank_go) begin
                stamp_n = now + TS_W'(T_LONG);
                state_n = BK_HOLD;
            end else if (ready || (remain < TS_W'(T_SHORT))) begin
                stamp_n = now + TS_W'(T_SHORT);
                state_n = BK_HOLD;
            end
        end
    end

endmodule

// File: rtl/act_xaw_window.sv
module act_xaw_window #(
    parameter int TS_W  = 16,
    parameter int T_XAW = 32,
    parameter int LIMIT = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TS_W-1:0] now,
    input  logic            go,
    output logic            ok
);

    generate
        if (T_XAW == 0) begin : g_off
            assign ok = 1'b1;
        end else begin : g_on
            // Slot 0 holds the newest expiry stamp, slot LIMIT-1 the oldest.
            logic [TS_W-1:0] exp_q [LIMIT];
            logic            live_q [LIMIT];
            logic            hit    [LIMIT];

            for (genvar i = 0; i < LIMIT; i++) begin : g_slot
                assign hit[i] = live_q[i] && (now == exp_q[i]);
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        live_q[i] <= 1'b0;
                        exp_q[i]  <= '0;
                    end else if (go) begin
                        if (i == 0) begin
                            live_q[i] <= 1'b1;
                            exp_q[i]  <= now + TS_W'(T_XAW);
                        end else begin
                            live_q[i] <= live_q[i-1] && !hit[i-1];
                            exp_q[i]  <= exp_q[i-1];
                        end
                    end else if (hit[i]) begin
                        live_q[i] <= 1'b0;
                    end
                end
            end

            assign ok = !live_q[LIMIT-1] || hit[LIMIT-1];
        end
    endgenerate

endmodule

// File: rtl/act_guard_top.sv
module act_guard_top
    import act_guard_pkg::*;
#(
    parameter int NUM_RANKS = 2,
    parameter int NUM_BANKS = 8,
    parameter int TS_W      = 16,
    parameter int T_RRD     = 5,
    parameter int T_RAS     = 28,
    parameter int T_RP      = 11,
    parameter int T_RCD     = 11,
    parameter int T_CL      = 11,
    parameter int T_XAW     = 32,
    parameter int ACT_LIMIT = 4,
    localparam int RANK_W   = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [RANK_W-1:0] req_rank,
    input  logic [BANK_W-1:0] req_bank,
    input  logic              issue,
    output logic              act_ok,
    output logic              stall,
    output logic              proto_err
);

    localparam int T_OWN = imax(T_RAS, T_RCD + T_CL) + T_RP;

    logic [TS_W-1:0] now;
    logic            go;
    logic            bank_rdy [NUM_RANKS][NUM_BANKS];
    logic            win_ok   [NUM_RANKS];
    logic            sel_rdy;

    always_ff @(posedge clk) begin
        if (!rst_n) now <= '0;
        else        now <= now + 1'b1;
    end

    assign go = issue && act_ok;

    for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
        logic rank_go;
        assign rank_go = go && (req_rank == RANK_W'(r));

        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            act_bank_timer #(
                .TS_W   (TS_W),
                .T_SHORT(T_RRD),
                .T_LONG (T_OWN)
            ) u_tmr (
                .clk    (clk),
                .rst_n  (rst_n),
                .now    (now),
                .rank_go(rank_go),
                .bank_go(req_bank == BANK_W'(b)),
                .ready  (bank_rdy[r][b])
            );
        end

        act_xaw_window #(
            .TS_W (TS_W),
            .T_XAW(T_XAW),
            .LIMIT(ACT_LIMIT)
        ) u_win (
            .clk  (clk),
            .rst_n(rst_n),
            .now  (now),
            .go   (rank_go),
            .ok   (win_ok[r])
        );
    end

    always_comb begin
        sel_rdy = 1'b0;
        for (int r = 0; r < NUM_RANKS; r++) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if ((req_rank == RANK_W'(r)) && (req_bank == BANK_W'(b)))
                    sel_rdy = bank_rdy[r][b] && win_ok[r];
            end
        end
    end

    assign act_ok    = req_valid && sel_rdy;
    assign stall     = req_valid && !act_ok;
    assign proto_err = issue && !act_ok;

endmodule

// File: rtl/act_guard_chk.sv
module act_guard_chk #(
    parameter int RANK_W = 1,
    parameter int BANK_W = 3,
    parameter int T_RRD  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [RANK_W-1:0] req_rank,
    input logic [BANK_W-1:0] req_bank,
    input logic              issue,
    input logic              act_ok,
    input logic              stall,
    input logic              proto_err
);

    logic              acc_q;
    logic [RANK_W-1:0] rank_q;
    logic [BANK_W-1:0] bank_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= 1'b0;
            rank_q <= '0;
            bank_q <= '0;
        end else begin
            acc_q  <= issue && act_ok;
            rank_q <= req_rank;
            bank_q <= req_bank;
        end
    end

    // R2
    ok_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_ok |-> req_valid);

    // R2
    stall_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(stall && act_ok));

    // R4
    same_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_q && req_rank == rank_q && req_bank == bank_q) |-> !act_ok);

    // R8
    err_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> (issue && !act_ok));

    generate
        if (T_RRD >= 2) begin : g_rrd
            // R3
            sibling_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (acc_q && req_rank == rank_q) |-> !act_ok);
        end
    endgenerate

endmodule

bind act_guard_top act_guard_chk #(
    .RANK_W(RANK_W),
    .BANK_W(BANK_W),
    .T_RRD (T_RRD)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_rank (req_rank),
    .req_bank (req_bank),
    .issue    (issue),
    .act_ok   (act_ok),
    .stall    (stall),
    .proto_err(proto_err)
);

// File: tb/sim_act_guard_top.sv
`timescale 1ns/1ps
module sim_act_guard_top;

    localparam int NR = 2, NB = 4, TSW = 5;
    localparam int RRD = 3, RAS = 5, RP = 2, RCD = 2, CL = 2;
    localparam int XAW = 10, LIM = 3;
    localparam int OWN = ((RAS > RCD + CL) ? RAS : RCD + CL) + RP;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, issue = 1'b0;
    logic [0:0] req_rank = '0;
    logic [1:0] req_bank = '0;
    logic ok0, st0, er0, ok1, st1, er1;

    int checks = 0, errors = 0, cyc = 100;
    bit done = 0;

    int rdy  [2][NR][NB];
    int hist [2][NR][LIM];
    int hcnt [2][NR];

    always #10 clk = ~clk;

    act_guard_top #(.NUM_RANKS(NR), .NUM_BANKS(NB), .TS_W(TSW), .T_RRD(RRD),
        .T_RAS(RAS), .T_RP(RP), .T_RCD(RCD), .T_CL(CL), .T_XAW(XAW),
        .ACT_LIMIT(LIM)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_rank(req_rank),
        .req_bank(req_bank), .issue(issue), .act_ok(ok0), .stall(st0),
        .proto_err(er0));

    act_guard_top #(.NUM_RANKS(NR), .NUM_BANKS(NB), .TS_W(TSW), .T_RRD(RRD),
        .T_RAS(RAS), .T_RP(RP), .T_RCD(RCD), .T_CL(CL), .T_XAW(0),
        .ACT_LIMIT(LIM)) u1 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_rank(req_rank),
        .req_bank(req_bank), .issue(issue), .act_ok(ok1), .stall(st1),
        .proto_err(er1));

    function automatic bit model_ok(int k, bit v, int r, int b);
        int x;
        x = (k == 0) ? XAW : 0;
        if (!v) return 0;
        if (cyc < rdy[k][r][b]) return 0;
        if (x > 0 && hcnt[k][r] == LIM && cyc < hist[k][r][LIM-1] + x) return 0;
        return 1;
    endfunction

    task automatic chk(string req, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s at cycle %0d: got %0d expected %0d", req, what, cyc, got, exp);
        end
    endtask

    task automatic commit(int k, int r, int b);
        for (int i = 0; i < NB; i++)
            if (rdy[k][r][i] < cyc + RRD) rdy[k][r][i] = cyc + RRD;
        rdy[k][r][b] = cyc + OWN;
        for (int i = LIM - 1; i > 0; i--) hist[k][r][i] = hist[k][r][i-1];
        hist[k][r][0] = cyc;
        if (hcnt[k][r] < LIM) hcnt[k][r]++;
    endtask

    // One cycle: drive on the falling edge, compare, then advance the model.
    task automatic step(string req, bit v, int r, int b, bit iss);
        bit e0, e1;
        @(negedge clk);
        req_valid = v; req_rank = r[0:0]; req_bank = b[1:0]; issue = iss;
        #1;
        e0 = model_ok(0, v, r, b);
        e1 = model_ok(1, v, r, b);
        chk(req, "act_ok u0", ok0, e0);
        chk("R7", "act_ok u1", ok1, e1);
        chk("R2", "stall u0", st0, v && !e0);
        chk("R8", "proto_err u0", er0, iss && !e0);
        chk("R8", "proto_err u1", er1, iss && !e1);
        @(posedge clk);
        if (iss && e0) commit(0, r, b);
        if (iss && e1) commit(1, r, b);
        cyc++;
    endtask

    initial begin
        int lfsr;
        for (int k = 0; k < 2; k++)
            for (int r = 0; r < NR; r++) begin
                hcnt[k][r] = 0;
                for (int b = 0; b < NB; b++) rdy[k][r][b] = 0;
                for (int i = 0; i < LIM; i++) hist[k][r][i] = 0;
            end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: everything allowed after reset
        for (int r = 0; r < NR; r++)
            for (int b = 0; b < NB; b++) step("R1", 1, r, b, 0);
        // R2: no request
        step("R2", 0, 0, 0, 0);
        // R3/R4: one activate, then watch sibling and own bank
        step("R3", 1, 0, 0, 1);
        for (int i = 0; i < RRD + 1; i++) step("R3", 1, 0, 1, 0);
        // R5: other rank free meanwhile
        step("R5", 1, 1, 2, 0);
        for (int i = 0; i < OWN; i++) step("R4", 1, 0, 0, 0);
        // R8: strobe while blocked is dropped
        step("R8", 1, 1, 1, 1);
        step("R8", 1, 1, 1, 1);
        step("R8", 1, 1, 2, 0);
        // R9: own-bank limit survives a sibling activate
        repeat (OWN) step("R9", 0, 0, 0, 0);
        step("R9", 1, 0, 0, 1);
        repeat (RRD) step("R9", 1, 0, 1, 1);
        for (int i = 0; i < OWN; i++) step("R9", 1, 0, 0, 0);
        // R6: greedy bursts into a rank, window limits the rate
        for (int i = 0; i < 80; i++) begin
            int b = i % NB;
            step("R6", 1, 0, b, model_ok(0, 1, 0, b));
        end
        // R10: long pseudo-random run across many counter wraps
        lfsr = 32'h1ace;
        for (int i = 0; i < 1500; i++) begin
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hb400 : 0);
            step("R10", lfsr[0] | lfsr[1], lfsr[2], lfsr[4:3], lfsr[5] | lfsr[6]);
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule